// File: doc/BRIEF.md
# Floating-point NaN resolution unit

This unit sits in front of a single-precision arithmetic datapath. Each cycle that `op_valid` is high, it looks at up to three 32-bit operands, an operation class and a default-NaN mode bit. One cycle later it reports whether the operation's result must be a NaN, and if so which 32-bit pattern that NaN carries. The datapath uses `res_nan` to choose this pattern over its own arithmetic result.

Arithmetic operations either propagate an operand NaN or substitute the canonical default NaN. Sign-only operations (move, absolute value, negate) and load/store transfers copy the first operand's NaN, with at most the sign bit altered. A sticky invalid-operation flag records every arithmetic operation that saw a signaling NaN. Only an explicit clear input brings the flag back down.

Top module: `nan_resolver`

## Requirements
- R1: An operand is a NaN only when bits 30:23 are all ones and bits 22:0 are not all zero; infinities (fraction zero) and ordinary numbers give `res_nan`=0 and `res_value`=0.
- R2: Results appear on the first clock edge after `op_valid` is sampled high; in a cycle following `op_valid` low, `res_valid`, `res_nan` and `res_value` are all zero.
- R3: For an arithmetic operation (`op_class`=3'b000) with `dn_mode`=1 and any NaN operand, `res_value` is 0x7FC00000 whatever the operand payloads.
- R4: For an arithmetic operation with `dn_mode`=0, if any operand is a signaling NaN (bit 22 = 0), the result is the lowest-numbered signaling NaN (a before b before c) with bit 22 set and all other bits kept.
- R5: For an arithmetic operation with `dn_mode`=0 and only quiet NaNs (bit 22 = 1), the result is the lowest-numbered quiet NaN unchanged.
- R6: Operand c takes part in an arithmetic operation only when `use_c`=1; otherwise a NaN on c has no effect on any output.
- R7: For move (3'b001), abs (3'b010) and negate (3'b011), a NaN in operand a is returned with the sign kept, cleared or inverted respectively, and the invalid flag is not set.
- R8: For a transfer (any `op_class` of 3'b100 or above), a NaN in operand a is returned bit-for-bit and the invalid flag is not set.
- R9: `ioc` is set one edge after an arithmetic operation with a signaling NaN among its active operands, in either mode; it stays set until `ioc_clear`, and a set in the same cycle as a clear wins.
- R10: After reset `res_valid`, `res_nan`, `res_value` and `ioc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_class | input | 3 | 000 arith, 001 move, 010 abs, 011 negate, 1xx transfer |
| dn_mode | input | 1 | Default-NaN mode |
| use_c | input | 1 | Third operand active for arithmetic |
| op_a | input | 32 | Operand a (source for sign-only and transfer) |
| op_b | input | 32 | Operand b |
| op_c | input | 32 | Operand c |
| ioc_clear | input | 1 | Clears the sticky invalid flag |
| res_valid | output | 1 | Result registers hold a fresh decision |
| res_nan | output | 1 | Result must be a NaN |
| res_value | output | 32 | NaN pattern to write, zero when no NaN |
| ioc | output | 1 | Sticky invalid-operation flag |

## Verification
Arithmetic cases use NaNs in each operand position and in pairs. Quiet-only mixes test the lowest-index rule. Mixes of signaling and quiet NaNs show that signaling NaNs take precedence and are quieted with the payload intact. The same NaNs are then sent with `dn_mode` set, to show that the payload is dropped and the flag still rises. A signaling NaN on c with `use_c` off shows that the third operand is gated. Negative signaling NaNs through move, abs, negate and transfer show the sign handling and that no flag is raised. Infinities and plain numbers show the boundary of the NaN test.

// File: rtl/nan_resolver.sv
module nan_resolver #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [2:0]                  op_class,
  input  logic                        dn_mode,
  input  logic                        use_c,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  input  logic [EXP_W+FRAC_W:0]       op_c,
  input  logic                        ioc_clear,
  output logic                        res_valid,
  output logic                        res_nan,
  output logic [EXP_W+FRAC_W:0]       res_value,
  output logic                        ioc
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int QBIT = FRAC_W - 1;
  localparam int NOPS = 3;
  localparam logic [W-1:0] QMASK = W'(1) << QBIT;
  localparam logic [W-1:0] DNAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [2:0] CL_ARITH = 3'b000;
  localparam logic [2:0] CL_MOV   = 3'b001;
  localparam logic [2:0] CL_ABS   = 3'b010;
  localparam logic [2:0] CL_NEG   = 3'b011;

  logic [W-1:0]    opnd [NOPS];
  logic [NOPS-1:0] is_nan, is_snan;
  logic [W-1:0]    pick, nxt_val;
  logic            nxt_nan, nxt_set;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;
  assign opnd[2] = op_c;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    logic active;
    assign active     = (i == NOPS - 1) ? use_c : 1'b1;
    assign is_nan[i]  = active && (&opnd[i][W-2:FRAC_W]) && (|opnd[i][FRAC_W-1:0]);
    assign is_snan[i] = is_nan[i] && !opnd[i][QBIT];
  end

  always_comb begin
    pick = '0;
    for (int i = NOPS - 1; i >= 0; i--)
      if (is_nan[i] && !(|is_snan)) pick = opnd[i];
    for (int i = NOPS - 1; i >= 0; i--)
      if (is_snan[i]) pick = opnd[i] | QMASK;
  end

  always_comb begin
    nxt_set = 1'b0;
    nxt_nan = is_nan[0];
    nxt_val = opnd[0];
    case (op_class)
      CL_ARITH: begin
        nxt_nan = |is_nan;
        nxt_set = |is_snan;
        nxt_val = dn_mode ? DNAN : pick;
      end
      CL_MOV:  nxt_val = opnd[0];
      CL_ABS:  nxt_val = {1'b0, opnd[0][W-2:0]};
      CL_NEG:  nxt_val = {~opnd[0][W-1], opnd[0][W-2:0]};
      default: nxt_val = opnd[0];
    endcase
    if (!nxt_nan) nxt_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_nan   <= 1'b0;
      res_value <= '0;
      ioc       <= 1'b0;
    end else begin
      res_valid <= op_valid;
      res_nan   <= op_valid && nxt_nan;
      res_value <= op_valid ? nxt_val : '0;
      ioc       <= (ioc && !ioc_clear) || (op_valid && nxt_set);
    end
  end

  a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(op_valid));
  a_r1_result_is_nan: assert property (@(posedge clk) disable iff (!rst_n)
    res_nan |-> (&res_value[W-2:FRAC_W]) && (|res_value[FRAC_W-1:0]));
  a_r3_default_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (res_nan && $past(dn_mode && op_class == CL_ARITH)) |-> res_value == DNAN);
  a_r4_arith_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (res_nan && $past(op_class == CL_ARITH)) |-> res_value[QBIT]);
  a_r8_transfer_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (res_nan && $past(op_class[2])) |-> res_value == $past(op_a));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ioc && !ioc_clear) |=> ioc);
  a_r9_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ioc) |-> $past(op_valid && op_class == CL_ARITH));
endmodule

// File: tb/tb_nan_resolver.sv
module tb_nan_resolver;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DNAN = 32'h7FC00000;

  typedef struct {
    string       tag;
    int          cyc;
    logic        valid;
    logic        nan;
    logic [31:0] value;
    logic        ioc;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0, dn_mode = 0, use_c = 0, ioc_clear = 0;
  logic [2:0]  op_class = 0;
  logic [31:0] op_a = 0, op_b = 0, op_c = 0;
  logic        res_valid, res_nan, ioc;
  logic [31:0] res_value;

  exp_t q[$];
  int   cyc = 0, checks = 0, fails = 0;
  logic model_ioc = 0;
  logic done = 0;

  nan_resolver dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .dn_mode(dn_mode), .use_c(use_c), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .ioc_clear(ioc_clear), .res_valid(res_valid), .res_nan(res_nan),
    .res_value(res_value), .ioc(ioc));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic isn(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic logic iss(logic [31:0] x);
    return isn(x) && !x[22];
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(string tag, logic v, logic [2:0] cls, logic dn, logic uc,
                       logic [31:0] a, logic [31:0] b, logic [31:0] c, logic clr);
    exp_t e;
    logic n, s;
    logic [31:0] val;
    @(negedge clk);
    op_valid = v; op_class = cls; dn_mode = dn; use_c = uc;
    op_a = a; op_b = b; op_c = c; ioc_clear = clr;
    n = 0; s = 0; val = 0;
    if (cls == 3'b000) begin
      n = isn(a) || isn(b) || (uc && isn(c));
      s = iss(a) || iss(b) || (uc && iss(c));
      if (dn) val = DNAN;
      else if (iss(a)) val = a | 32'h0040_0000;
      else if (iss(b)) val = b | 32'h0040_0000;
      else if (uc && iss(c)) val = c | 32'h0040_0000;
      else if (isn(a)) val = a;
      else if (isn(b)) val = b;
      else if (uc && isn(c)) val = c;
    end else begin
      n = isn(a);
      case (cls)
        3'b010:  val = {1'b0, a[30:0]};
        3'b011:  val = {~a[31], a[30:0]};
        default: val = a;
      endcase
    end
    if (!n) val = 0;
    model_ioc = (model_ioc && !clr) || (v && s);
    e.tag = tag; e.cyc = cyc; e.valid = v; e.nan = v && n;
    e.value = v ? val : 32'h0; e.ioc = model_ioc;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc < cyc) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "res_valid", 32'(res_valid), 32'(e.valid));
      check(e.tag, "res_nan", 32'(res_nan), 32'(e.nan));
      check(e.tag, "res_value", res_value, e.value);
      check(e.tag, "ioc", 32'(ioc), 32'(e.ioc));
    end
  end

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "res_valid", 32'(res_valid), 0);
    check("R10", "ioc", 32'(ioc), 0);
    check("R10", "res_value", res_value, 0);
    rst_n = 1;
    // R1: numbers and infinities
    drive("R1", 1, 3'b000, 0, 1, 32'h3F800000, 32'h7F800000, 32'hFF800000, 0);
    drive("R1", 1, 3'b000, 1, 1, 32'h7F800000, 32'h00000001, 32'h40000000, 0);
    // R5: quiet NaNs only
    drive("R5", 1, 3'b000, 0, 0, 32'h3F800000, 32'hFFC12345, 32'h0, 0);
    drive("R5", 1, 3'b000, 0, 1, 32'h7FC00ABC, 32'hFFC12345, 32'h7FE00001, 0);
    drive("R5", 1, 3'b000, 0, 1, 32'h1, 32'h2, 32'h7FD00007, 0);
    // R2: idle gap
    drive("R2", 0, 3'b000, 0, 1, 32'h7F800001, 32'h0, 32'h0, 0);
    // R4: signaling beats quiet, lowest index wins, payload kept
    drive("R4", 1, 3'b000, 0, 0, 32'h7FC00001, 32'hFF812345, 32'h0, 0);
    drive("R9", 1, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 0);
    drive("R9", 0, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 1);
    drive("R4", 1, 3'b000, 0, 1, 32'h7FA00001, 32'h7FC00000, 32'hFF800005, 0);
    drive("R4", 1, 3'b000, 0, 1, 32'h7FC00003, 32'h7FC00004, 32'h7F800009, 1);
    drive("R9", 0, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 1);
    // R6: gated third operand
    drive("R6", 1, 3'b000, 0, 0, 32'h3F800000, 32'h40000000, 32'h7F800001, 0);
    drive("R6", 1, 3'b000, 1, 0, 32'h3F800000, 32'h40000000, 32'h7F800001, 0);
    // R3: default NaN mode
    drive("R3", 1, 3'b000, 1, 1, 32'hFFC0BEEF, 32'h0, 32'h0, 0);
    drive("R3", 1, 3'b000, 1, 1, 32'h0, 32'h7F800ABC, 32'h0, 0);
    drive("R9", 1, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 1);
    // R7: sign-only operations, no flag
    drive("R7", 1, 3'b001, 0, 1, 32'hFF800011, 32'h7F800001, 32'h7F800001, 0);
    drive("R7", 1, 3'b010, 1, 1, 32'hFF800022, 32'h0, 32'h0, 0);
    drive("R7", 1, 3'b011, 0, 1, 32'hFF800033, 32'h0, 32'h0, 0);
    drive("R7", 1, 3'b011, 0, 1, 32'h7FC00044, 32'h0, 32'h0, 0);
    drive("R7", 1, 3'b010, 0, 1, 32'hFF800000, 32'h0, 32'h0, 0);
    // R8: transfers
    drive("R8", 1, 3'b100, 1, 1, 32'hFF800055, 32'h7F800001, 32'h0, 0);
    drive("R8", 1, 3'b110, 0, 1, 32'h7FBFFFFF, 32'h0, 32'h0, 0);
    drive("R8", 1, 3'b111, 0, 1, 32'h3F800000, 32'hFF800001, 32'h0, 0);
    // R9: set wins over clear, then clear
    drive("R9", 1, 3'b000, 1, 0, 32'h7F800001, 32'h0, 32'h0, 1);
    drive("R9", 0, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 0);
    drive("R9", 0, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 1);
    drive("R2", 0, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 0);
    drive("R2", 0, 3'b000, 0, 0, 32'h0, 32'h0, 32'h0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule